// File: doc/BRIEF.md
# Three-Phase Bridge Gate Drive Combiner

This block sits between a six-step commutation sequencer and the gate drivers of a three-phase half-bridge power stage. It takes the raw per-phase switch requests from the sequencer and produces the final six gate signals. The high-side gates are active low and the low-side gates are active high. Speed regulation comes from a digital sawtooth carrier that is compared against a duty word. Current protection comes from an over-current flag, which starts a programmable off-time. While the off-time runs, the low-side switches are held off.

There are three override conditions: a brake request, an undervoltage lockout and a one-time cross-conduction interlock. The interlock applies to phase C after reset. Chopping, from either the PWM or the current limit, acts only on the low-side switches. The high sides follow the sequencer directly unless an override applies. All six gate outputs and the fault flag come from one register stage, so they switch together on a single clock edge. That edge follows the cycle in which the inputs were sampled.

Top module: `bridge_gate_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, the outputs are `hs_n_o` = 3'b111 (all high sides off), `ls_o` = 3'b000 and `fault_n_o` = 1. Bit 0 of each 3-bit bus is phase A, bit 1 is phase B and bit 2 is phase C.
- R2: Consider normal operation with carrier period P > 1 and duty word D < P. Each enabled low side is on for exactly D of every P clock cycles. `hs_n_o` is the bitwise inverse of `hi_en_i`, delayed by one cycle, and is not chopped.
- R3: Each rising of the over-current flag is seen after a two-flop synchroniser. When it is seen, all three low sides are forced off for `off_time_i` cycles and then released. The high sides are not affected.
- R4: While brake is asserted and undervoltage is not, `ls_o` = 3'b111 and `hs_n_o` = 3'b111. The current limit has no effect on the outputs during brake.
- R5: While undervoltage is asserted, all six switches are off (`hs_n_o` = 3'b111, `ls_o` = 3'b000) and `fault_n_o` = 0.
- R6: After reset, low side C is held off until `hsc_off_fb_i` = 1 is seen while high side C is not requested. After that point the hold never returns until the next reset.
- R7: Undervoltage has priority over brake, and brake has priority over normal gating.
- R8: A duty word of 0 gives 0% low-side on-time. A duty word equal to or above the period gives 100% low-side on-time.
- R9: An over-current trip that arrives while the off-time is still running is ignored. It does not extend the off-time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hi_en_i | input | 3 | Raw high-side requests from the sequencer (1 = on), bits C,B,A |
| lo_en_i | input | 3 | Raw low-side requests from the sequencer (1 = on), bits C,B,A |
| duty_i | input | 8 | PWM duty word, in carrier counts |
| period_i | input | 8 | Carrier period, in clock cycles |
| off_time_i | input | 10 | Current-limit off-time, in clock cycles (0 is treated as 1) |
| oc_i | input | 1 | Asynchronous over-current flag, active high |
| brake_i | input | 1 | Brake request, active high |
| uv_i | input | 1 | Undervoltage indication, active high |
| hsc_off_fb_i | input | 1 | Feedback that high-side switch C is really off |
| hs_n_o | output | 3 | High-side gate drives, active low |
| ls_o | output | 3 | Low-side gate drives, active high |
| fault_n_o | output | 1 | Undervoltage fault, active low |

## Verification
The bench counts low-side on-cycles over whole carrier periods at a fractional duty, at zero duty and at duty words at and above the period. A design with an off-by-one compare, or with a missing saturation at full duty, would return the wrong count. The bench fires one over-current pulse and then a second pulse while the off-time is still running. It then checks that the low sides come back at the time set by the first trip alone; a design that reloads the counter would still be blanking at that time. The cross-conduction hold is checked before and after the feedback, and again once the feedback drops. This catches a design that never releases low side C or that re-arms the hold. Brake and undervoltage are checked together and separately, together with an over-current pulse during brake. A wrong priority order, or a current limit that stays active during brake, would show up as wrong gate patterns.

// File: rtl/bgc_pkg.sv
// Package: shared widths and the phase index names of the gate combiner.
package bgc_pkg;
    localparam int PHASES   = 3;
    localparam int PH_A     = 0;
    localparam int PH_B     = 1;
    localparam int PH_C     = 2;
    localparam int CNT_W    = 8;
    localparam int OFF_W    = 10;

    typedef logic [PHASES-1:0] phase_vec_t;
endpackage

// File: rtl/bgc_pwm_carrier.sv
// Sawtooth carrier and duty compare.
// Function: a counter runs 0..period-1 and wraps. The duty request is high while
// the count is below the duty word, and always high when duty >= period.
// Assumes: period <= 1 holds the counter at 0. The output is combinational; the
// top-level output stage registers it.
module bgc_pwm_carrier #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] duty_i,
    output logic             pwm_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             wrap;

    // Purpose: the wrap point of the sawtooth
    always_comb begin
        wrap = (period_i <= ONE) || (cnt_q >= period_i - ONE);
    end

    // Purpose: advance the sawtooth counter
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (wrap)   cnt_q <= '0;
        else             cnt_q <= cnt_q + ONE;
    end

    // Purpose: duty compare, saturating to full on
    always_comb begin
        if (duty_i >= period_i) pwm_o = 1'b1;
        else                    pwm_o = (cnt_q < duty_i);
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (period_i > ONE) && $stable(period_i) |-> cnt_q < period_i);   // R2
endmodule

// File: rtl/bgc_ilim_oneshot.sv
// Fixed off-time current-limit one-shot.
// Function: synchronises the asynchronous over-current flag through two flops.
// When the synchronised flag is high and no off-time is running, it loads the
// off-time counter. The blank output is high while the counter is non-zero.
// Assumes: a trip that arrives during a running off-time is ignored. An
// off-time of 0 is treated as 1.
module bgc_ilim_oneshot #(
    parameter int OFF_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             oc_i,
    input  logic [OFF_W-1:0] off_time_i,
    output logic             blank_o
);
    localparam logic [OFF_W-1:0] ONE = OFF_W'(1);

    logic             s1_q, s2_q;
    logic [OFF_W-1:0] cnt_q;
    logic [OFF_W-1:0] load_val;

    // Purpose: two-flop synchroniser for the over-current flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else begin
            s1_q <= oc_i;
            s2_q <= s1_q;
        end
    end

    // Purpose: clamp the off-time to at least one cycle
    always_comb begin
        load_val = (off_time_i == '0) ? ONE : off_time_i;
    end

    // Purpose: off-time down-counter; reload only from idle
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (cnt_q != '0)            cnt_q <= cnt_q - ONE;
        else if (s2_q)                   cnt_q <= load_val;
    end

    assign blank_o = (cnt_q != '0);

    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q > ONE) |=> cnt_q == $past(cnt_q) - ONE);   // R9
endmodule

// File: rtl/bgc_xc_interlock.sv
// One-time cross-conduction interlock for phase C.
// Function: armed by reset. While armed, it asks the output stage to hold low
// side C off. It disarms once the feedback shows high side C is off while high
// side C is not requested. After that it stays disarmed until the next reset.
// Assumes: the feedback input is already synchronous to clk.
module bgc_xc_interlock (
    input  logic clk,
    input  logic rst_n,
    input  logic hsc_req_i,
    input  logic hsc_off_fb_i,
    output logic hold_o
);
    logic armed_q;

    // Purpose: arm on reset and disarm once on confirmed high-side-C off
    always_ff @(posedge clk) begin
        if (!rst_n)                               armed_q <= 1'b1;
        else if (armed_q && hsc_off_fb_i && !hsc_req_i) armed_q <= 1'b0;
    end

    assign hold_o = armed_q;

    AST_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_q |=> !armed_q);   // R6
endmodule

// File: rtl/bridge_gate_ctrl.sv
// Three-phase bridge gate drive combiner (top).
// Function: merges the raw six-step requests with PWM, the current-limit
// blank, brake, undervoltage and the phase C interlock. The six gate outputs
// and the fault flag are registered together.
// Assumes: priority is undervoltage > brake > normal. PWM, blank and the
// interlock act on the low sides only.
module bridge_gate_ctrl #(
    parameter int CNT_W = bgc_pkg::CNT_W,
    parameter int OFF_W = bgc_pkg::OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       hi_en_i,
    input  logic [2:0]       lo_en_i,
    input  logic [CNT_W-1:0] duty_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [OFF_W-1:0] off_time_i,
    input  logic             oc_i,
    input  logic             brake_i,
    input  logic             uv_i,
    input  logic             hsc_off_fb_i,
    output logic [2:0]       hs_n_o,
    output logic [2:0]       ls_o,
    output logic             fault_n_o
);
    import bgc_pkg::*;

    logic       pwm_w, blank_w, xc_hold_w;
    phase_vec_t hs_n_d, ls_d, ls_mask;
    logic       fault_n_d;

    bgc_pwm_carrier #(.CNT_W(CNT_W)) u_carrier (
        .clk      (clk),
        .rst_n    (rst_n),
        .period_i (period_i),
        .duty_i   (duty_i),
        .pwm_o    (pwm_w)
    );

    bgc_ilim_oneshot #(.OFF_W(OFF_W)) u_ilim (
        .clk        (clk),
        .rst_n      (rst_n),
        .oc_i       (oc_i),
        .off_time_i (off_time_i),
        .blank_o    (blank_w)
    );

    bgc_xc_interlock u_xc (
        .clk          (clk),
        .rst_n        (rst_n),
        .hsc_req_i    (hi_en_i[PH_C]),
        .hsc_off_fb_i (hsc_off_fb_i),
        .hold_o       (xc_hold_w)
    );

    // Purpose: per-phase low-side enable mask from PWM, blank and interlock
    for (genvar p = 0; p < PHASES; p++) begin : g_mask
        if (p == PH_C) begin : g_c
            assign ls_mask[p] = pwm_w && !blank_w && !xc_hold_w;
        end else begin : g_ab
            assign ls_mask[p] = pwm_w && !blank_w;
        end
    end

    // Purpose: priority selection of the next gate pattern
    always_comb begin
        fault_n_d = 1'b1;
        if (uv_i) begin
            hs_n_d    = '1;
            ls_d      = '0;
            fault_n_d = 1'b0;
        end else if (brake_i) begin
            hs_n_d = '1;
            ls_d   = '1;
        end else begin
            hs_n_d = ~hi_en_i;
            ls_d   = lo_en_i & ls_mask;
        end
    end

    // Purpose: single output register stage for all gates and the fault flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_n_o    <= '1;
            ls_o      <= '0;
            fault_n_o <= 1'b1;
        end else begin
            hs_n_o    <= hs_n_d;
            ls_o      <= ls_d;
            fault_n_o <= fault_n_d;
        end
    end

    AST_UV_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        uv_i |=> (hs_n_o == 3'b111) && (ls_o == 3'b000) && !fault_n_o);   // R5
    AST_BRAKE_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        brake_i && !uv_i |=> (hs_n_o == 3'b111) && (ls_o == 3'b111));   // R4
    AST_BLANK_LS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        blank_w && !brake_i |=> ls_o == 3'b000);   // R3
    AST_XC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        xc_hold_w && !brake_i |=> !ls_o[PH_C]);   // R6
    AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_i == '0) && !brake_i |=> ls_o == 3'b000);   // R8
    AST_HS_UNCHOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !uv_i && !brake_i |=> hs_n_o == ~$past(hi_en_i));   // R2
endmodule

// File: tb/tb_bridge_gate_ctrl.sv
module tb_bridge_gate_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] hi_en, lo_en;
    logic [7:0] duty, period;
    logic [9:0] off_time;
    logic       oc, brake, uv, fb;
    logic [2:0] hs_n, ls;
    logic       fault_n;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    bridge_gate_ctrl dut (
        .clk(clk), .rst_n(rst_n), .hi_en_i(hi_en), .lo_en_i(lo_en),
        .duty_i(duty), .period_i(period), .off_time_i(off_time),
        .oc_i(oc), .brake_i(brake), .uv_i(uv), .hsc_off_fb_i(fb),
        .hs_n_o(hs_n), .ls_o(ls), .fault_n_o(fault_n)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // R1: reset state
    task automatic t_reset();
        rst_n = 1'b0; hi_en = 3'b000; lo_en = 3'b000; duty = 8'd0; period = 8'd10;
        off_time = 10'd20; oc = 1'b0; brake = 1'b0; uv = 1'b0; fb = 1'b0;
        step(3);
        chk(hs_n == 3'b111, "R1 hs_n", hs_n, 3'b111);
        chk(ls == 3'b000, "R1 ls", ls, 0);
        chk(fault_n == 1'b1, "R1 fault_n", fault_n, 1);
        @(negedge clk); rst_n = 1'b1;
        step(1);
        chk(hs_n == 3'b111 && ls == 3'b000, "R1 first cycle", {hs_n, ls}, 6'b111000);
    endtask

    // R6: phase C low side held until confirmed high-side C off, once only
    task automatic t_interlock();
        @(negedge clk); hi_en = 3'b000; lo_en = 3'b100; duty = 8'd255;
        step(3);
        chk(ls[2] == 1'b0, "R6 held", ls, 0);
        @(negedge clk); fb = 1'b1;
        step(2);
        chk(ls[2] == 1'b1, "R6 released", ls, 3'b100);
        @(negedge clk); fb = 1'b0;
        step(3);
        chk(ls[2] == 1'b1, "R6 no rearm", ls, 3'b100);
        @(negedge clk); fb = 1'b1;
    endtask

    // R2/R8: count low-side on cycles over ten carrier periods
    task automatic t_pwm(input logic [7:0] d, input int exp_on, input string req);
        int on_cnt = 0;
        @(negedge clk); hi_en = 3'b010; lo_en = 3'b001; duty = d; period = 8'd10;
        step(3);
        for (int i = 0; i < 100; i++) begin
            step(1);
            if (ls[0]) on_cnt++;
            if (hs_n != 3'b101) begin
                chk(1'b0, "R2 high side unchopped", hs_n, 3'b101);
            end
        end
        chk(on_cnt == exp_on, req, on_cnt, exp_on);
    endtask

    // R3/R9: off-time blanking and trip ignored while running
    task automatic t_oc();
        @(negedge clk); hi_en = 3'b010; lo_en = 3'b111; duty = 8'd255; off_time = 10'd20;
        step(3);
        chk(ls == 3'b111, "R3 before trip", ls, 3'b111);
        @(negedge clk); oc = 1'b1;
        @(posedge clk);
        @(negedge clk); oc = 1'b0;
        repeat (9) @(posedge clk); #1;
        chk(ls == 3'b000, "R3 blanked", ls, 0);
        chk(hs_n == 3'b101, "R3 high side kept", hs_n, 3'b101);
        repeat (4) @(posedge clk);
        @(negedge clk); oc = 1'b1;
        @(posedge clk);
        @(negedge clk); oc = 1'b0;
        repeat (15) @(posedge clk); #1;
        chk(ls == 3'b111, "R9 retrigger ignored / R3 released", ls, 3'b111);
    endtask

    // R4: brake pattern, current limit without effect
    task automatic t_brake();
        @(negedge clk); hi_en = 3'b001; lo_en = 3'b010; brake = 1'b1;
        step(2);
        chk(ls == 3'b111 && hs_n == 3'b111, "R4 brake", {hs_n, ls}, 6'b111111);
        @(negedge clk); oc = 1'b1;
        @(negedge clk); oc = 1'b0;
        step(5);
        chk(ls == 3'b111, "R4 no current limit in brake", ls, 3'b111);
        @(negedge clk); brake = 1'b0;
        step(30);
        chk(hs_n == 3'b110 && ls == 3'b010, "R4 brake release", {hs_n, ls}, 6'b110010);
    endtask

    // R5/R7: undervoltage and priority
    task automatic t_uv();
        @(negedge clk); uv = 1'b1; brake = 1'b1;
        step(2);
        chk(hs_n == 3'b111 && ls == 3'b000, "R7 uv over brake", {hs_n, ls}, 6'b111000);
        chk(fault_n == 1'b0, "R5 fault low", fault_n, 0);
        @(negedge clk); brake = 1'b0;
        step(2);
        chk(hs_n == 3'b111 && ls == 3'b000 && !fault_n, "R5 all off", {fault_n, hs_n, ls}, 7'b0111000);
        @(negedge clk); uv = 1'b0; brake = 1'b1;
        step(2);
        chk(ls == 3'b111 && fault_n, "R7 brake over normal", {fault_n, ls}, 4'b1111);
        @(negedge clk); brake = 1'b0;
        step(2);
        chk(hs_n == 3'b110 && ls == 3'b010, "R7 normal", {hs_n, ls}, 6'b110010);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_interlock();
                t_pwm(8'd3, 30, "R2 duty 3/10");
                t_pwm(8'd7, 70, "R2 duty 7/10");
                t_pwm(8'd0, 0, "R8 duty zero");
                t_pwm(8'd10, 100, "R8 duty equal period");
                t_pwm(8'd200, 100, "R8 duty above period");
                t_oc();
                t_brake();
                t_uv();
            end
            begin
                repeat (100000) @(posedge clk);
                chk(1'b0, "watchdog", 0, 1);
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule